// File: doc/BRIEF.md
# Configuration Access Bridge

This block sits in a host bridge and turns processor I/O port accesses into configuration transactions for the attached bus. Software first writes a pointer word to an address port. That word names a bus, a device, a function and a dword register. Software then reads or writes a data port. Each data-port access becomes one configuration request. The request carries a formatted address, a command code, byte enables and write data. The bridge holds the host side until the target reports completion or a timeout expires.

The latched bus number selects the request form. For bus 0 the bridge emits a local form and drives a one-hot device select line picked from the device field. For any other bus it emits a forwarding form that carries every pointer field through unchanged. A pointer whose enable bit is clear blocks the data port. Accesses at any other address complete at once and change nothing. Only one access is in flight at a time.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the pointer register reads as zero, `host_ready` is 1, and `cfg_req` and `host_done` are 0.
- R2: A write to address 0x0CF8 with all four byte enables set loads the pointer register. Any other byte-enable pattern leaves it unchanged. A read at 0x0CF8 returns the pointer with bits 30:24 forced to zero. Pointer fields: enable in bit 31, bus in bits 23:16, device in bits 15:11, function in bits 10:8, dword index in bits 7:2, and a software-owned code in bits 1:0.
- R3: A data-port access (address 0x0CFC) while pointer bit 31 is 0 raises no request. A read returns 0xFFFFFFFF and a write is dropped. `host_done` is high in the cycle after the access is accepted.
- R4: A data-port access while pointer bit 31 is 1 raises `cfg_req` in the cycle after acceptance. The command is 4'b1010 for a read and 4'b1011 for a write. `cfg_be` and `cfg_wdata` carry the host byte enables and data.
- R5: With bus 0 the request address is {21'b0, function, dword, 2'b00}. `cfg_idsel` has only the bit numbered by the device field set, or no bit when the device number is NUM_DEV or above.
- R6: With a non-zero bus the request address is {8'b0, bus, device, function, dword, 2'b01} and `cfg_idsel` is zero.
- R7: While `cfg_req` is high its command, address, byte enables and select stay stable. `host_ready` stays low from acceptance until `host_done`.
- R8: When `cfg_done` is sampled high with a request pending, the request drops. `host_done` rises in the next cycle. For a read, `host_rdata` then carries the `cfg_rdata` value sampled with `cfg_done`.
- R9: A request left without `cfg_done` is withdrawn after TIMEOUT_CYCLES cycles high. The host then gets `host_done` with 0xFFFFFFFF.
- R10: An access to any address other than exactly 0x0CF8 or 0x0CFC raises no request and changes no state. It completes in the next cycle, and a read returns 0xFFFFFFFF.
- R11: `host_done` is a single-cycle pulse, and each accepted access produces exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access strobe, accepted when `host_ready` is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Host I/O port address |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Bridge idle and able to accept an access |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_done` |
| cfg_req | output | 1 | Configuration request pending |
| cfg_cmd | output | 4 | Command code (read or write) |
| cfg_addr | output | 32 | Formatted configuration address |
| cfg_be | output | 4 | Request byte enables |
| cfg_wdata | output | 32 | Request write data |
| cfg_idsel | output | NUM_DEV | One-hot device select for bus 0 |
| cfg_done | input | 1 | Target completion |
| cfg_rdata | input | 32 | Target read data, sampled with `cfg_done` |

## Verification
The bench sweeps the pointer over bus 0, bus 1 and bus 255. For each bus it walks every device number from 0 to two past the select width, and it varies the function and dword fields with the device. Each pointer is followed by a data read and a data write. This separates the local and forwarding address forms, the placement of each field, and select lines that are missing or out of range. The target answers after one to three cycles, or not at all, which tells a held request apart from early completion and from the timeout. Pointer writes with partial byte enables, blocked data-port accesses and stray addresses check that nothing leaks through when it should not.

// File: rtl/cfgb_pkg.sv
// Package: shared constants and types for the configuration access bridge.
// Assumes a 32-bit host I/O address and dword-aligned port addresses.
package cfgb_pkg;
    localparam logic [31:0] PTR_PORT_ADDR  = 32'h0000_0CF8;
    localparam logic [31:0] DATA_PORT_ADDR = 32'h0000_0CFC;
    localparam logic [3:0]  CMD_CFG_READ   = 4'b1010;
    localparam logic [3:0]  CMD_CFG_WRITE  = 4'b1011;
    localparam logic [31:0] PTR_KEEP_MASK  = 32'h80FF_FFFF;
    localparam logic [31:0] FLOAT_DATA     = 32'hFFFF_FFFF;
    localparam int          PTR_EN_BIT     = 31;

    // Which host port an access targets
    typedef enum logic [1:0] {
        PORT_OTHER = 2'd0,
        PORT_PTR   = 2'd1,
        PORT_DATA  = 2'd2
    } port_e;

    // Sequencer state
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_RESP = 2'd2
    } seq_e;

    // Pointer fields used to build a request
    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] dword;
    } ptr_fields_t;
endpackage

// File: rtl/cfgb_port_decode.sv
// Module: cfgb_port_decode
// Classifies a host address as pointer port, data port or other, and
// flags full-dword byte enables. Pure combinational; needs exact matches.
module cfgb_port_decode
    import cfgb_pkg::*;
(
    input  logic [31:0] host_addr,
    input  logic [3:0]  host_be,
    output port_e       port,
    output logic        full_word
);
    // Exact address compare selects the port
    always_comb begin
        if (host_addr == PTR_PORT_ADDR) begin
            port = PORT_PTR;
        end else if (host_addr == DATA_PORT_ADDR) begin
            port = PORT_DATA;
        end else begin
            port = PORT_OTHER;
        end
    end

    // All four lanes enabled
    assign full_word = &host_be;
endmodule

// File: rtl/cfgb_addr_latch.sv
// Module: cfgb_addr_latch
// Holds the pointer word. Reserved bits are stored as zero so a read
// returns them cleared. Assumes load is a single-cycle qualified strobe.
module cfgb_addr_latch
    import cfgb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] wdata,
    output logic [31:0] value
);
    // Pointer register with masked load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= wdata & PTR_KEEP_MASK;
        end
    end
endmodule

// File: rtl/cfgb_req_format.sv
// Module: cfgb_req_format
// Builds the request address and device select from the pointer fields.
// Bus 0 gives the local form with a one-hot select; other buses give the
// forwarding form with no select. Assumes NUM_DEV <= 32.
module cfgb_req_format
    import cfgb_pkg::*;
#(
    parameter int NUM_DEV = 32
) (
    input  ptr_fields_t         fields,
    output logic [31:0]         req_addr,
    output logic [NUM_DEV-1:0]  req_idsel
);
    logic local_bus;

    // Bus 0 means a device on the local segment
    assign local_bus = (fields.bus == 8'd0);

    // Address form chosen by the bus number
    always_comb begin
        if (local_bus) begin
            req_addr = {21'd0, fields.func, fields.dword, 2'b00};
        end else begin
            req_addr = {8'd0, fields.bus, fields.dev, fields.func,
                        fields.dword, 2'b01};
        end
    end

    // One select line per device slot
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_idsel
        assign req_idsel[g] = local_bus && (fields.dev == 5'(g));
    end
endmodule

// File: rtl/cfgb_ctrl.sv
// Module: cfgb_ctrl
// Sequences host accesses: accepts one at a time, issues a configuration
// request for enabled data-port accesses, waits for completion or timeout,
// and returns one done pulse. Assumes TIMEOUT_CYCLES >= 2.
module cfgb_ctrl
    import cfgb_pkg::*;
#(
    parameter int NUM_DEV        = 32,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [3:0]         host_be,
    input  logic [31:0]        host_wdata,
    input  port_e              port,
    input  logic               full_word,
    input  logic [31:0]        ptr_value,
    input  logic [31:0]        fmt_addr,
    input  logic [NUM_DEV-1:0] fmt_idsel,
    input  logic               cfg_done,
    input  logic [31:0]        cfg_rdata,
    output logic               ptr_load,
    output logic               host_ready,
    output logic               host_done,
    output logic [31:0]        host_rdata,
    output logic               cfg_req,
    output logic [3:0]         cfg_cmd,
    output logic [31:0]        cfg_addr,
    output logic [3:0]         cfg_be,
    output logic [31:0]        cfg_wdata,
    output logic [NUM_DEV-1:0] cfg_idsel
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    seq_e             state;
    logic [CNT_W-1:0] wait_cnt;
    logic             accept;
    logic             forward;

    // Handshake and routing decisions for the current host access
    assign host_ready = (state == SQ_IDLE);
    assign accept     = host_valid && host_ready;
    assign forward    = (port == PORT_DATA) && ptr_value[PTR_EN_BIT];
    assign ptr_load   = accept && host_write && (port == PORT_PTR) && full_word;

    // Sequencer, request registers and host response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            wait_cnt   <= '0;
            host_done  <= 1'b0;
            host_rdata <= '0;
            cfg_req    <= 1'b0;
            cfg_cmd    <= CMD_CFG_READ;
            cfg_addr   <= '0;
            cfg_be     <= '0;
            cfg_wdata  <= '0;
            cfg_idsel  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    host_done <= 1'b0;
                    if (accept) begin
                        if (forward) begin
                            state     <= SQ_WAIT;
                            wait_cnt  <= '0;
                            cfg_req   <= 1'b1;
                            cfg_cmd   <= host_write ? CMD_CFG_WRITE : CMD_CFG_READ;
                            cfg_addr  <= fmt_addr;
                            cfg_be    <= host_be;
                            cfg_wdata <= host_wdata;
                            cfg_idsel <= fmt_idsel;
                        end else begin
                            state     <= SQ_RESP;
                            host_done <= 1'b1;
                            if (!host_write && (port == PORT_PTR)) begin
                                host_rdata <= ptr_value;
                            end else begin
                                host_rdata <= FLOAT_DATA;
                            end
                        end
                    end
                end
                SQ_WAIT: begin
                    if (cfg_done) begin
                        state      <= SQ_RESP;
                        cfg_req    <= 1'b0;
                        cfg_idsel  <= '0;
                        host_done  <= 1'b1;
                        host_rdata <= (cfg_cmd == CMD_CFG_READ) ? cfg_rdata : FLOAT_DATA;
                    end else if (wait_cnt == CNT_LAST) begin
                        state      <= SQ_RESP;
                        cfg_req    <= 1'b0;
                        cfg_idsel  <= '0;
                        host_done  <= 1'b1;
                        host_rdata <= FLOAT_DATA;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                SQ_RESP: begin
                    host_done <= 1'b0;
                    state     <= SQ_IDLE;
                end
                default: begin
                    state     <= SQ_IDLE;
                    host_done <= 1'b0;
                    cfg_req   <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_access_bridge.sv
// Module: cfg_access_bridge
// Top: two-port indirection from host I/O accesses to configuration
// requests. Wires decode, pointer register, request formatter and
// sequencer. Assumes a single host master and NUM_DEV <= 32.
module cfg_access_bridge
    import cfgb_pkg::*;
#(
    parameter int NUM_DEV        = 32,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [31:0]        host_addr,
    input  logic [3:0]         host_be,
    input  logic [31:0]        host_wdata,
    output logic               host_ready,
    output logic               host_done,
    output logic [31:0]        host_rdata,
    output logic               cfg_req,
    output logic [3:0]         cfg_cmd,
    output logic [31:0]        cfg_addr,
    output logic [3:0]         cfg_be,
    output logic [31:0]        cfg_wdata,
    output logic [NUM_DEV-1:0] cfg_idsel,
    input  logic               cfg_done,
    input  logic [31:0]        cfg_rdata
);
    port_e              port;
    logic               full_word;
    logic               ptr_load;
    logic [31:0]        ptr_value;
    ptr_fields_t        fields;
    logic [31:0]        fmt_addr;
    logic [NUM_DEV-1:0] fmt_idsel;

    // Pointer fields feeding the formatter
    assign fields = '{bus: ptr_value[23:16], dev: ptr_value[15:11],
                      func: ptr_value[10:8], dword: ptr_value[7:2]};

    cfgb_port_decode u_decode (
        .host_addr (host_addr),
        .host_be   (host_be),
        .port      (port),
        .full_word (full_word)
    );

    cfgb_addr_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_load),
        .wdata (host_wdata),
        .value (ptr_value)
    );

    cfgb_req_format #(.NUM_DEV(NUM_DEV)) u_format (
        .fields    (fields),
        .req_addr  (fmt_addr),
        .req_idsel (fmt_idsel)
    );

    cfgb_ctrl #(.NUM_DEV(NUM_DEV), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_be    (host_be),
        .host_wdata (host_wdata),
        .port       (port),
        .full_word  (full_word),
        .ptr_value  (ptr_value),
        .fmt_addr   (fmt_addr),
        .fmt_idsel  (fmt_idsel),
        .cfg_done   (cfg_done),
        .cfg_rdata  (cfg_rdata),
        .ptr_load   (ptr_load),
        .host_ready (host_ready),
        .host_done  (host_done),
        .host_rdata (host_rdata),
        .cfg_req    (cfg_req),
        .cfg_cmd    (cfg_cmd),
        .cfg_addr   (cfg_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_idsel  (cfg_idsel)
    );
endmodule

// File: rtl/cfg_access_bridge_chk.sv
// Module: cfg_access_bridge_chk
// Port-level protocol checks for cfg_access_bridge, attached by bind.
module cfg_access_bridge_chk #(
    parameter int NUM_DEV = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_ready,
    input logic               host_done,
    input logic               cfg_req,
    input logic               cfg_done,
    input logic [3:0]         cfg_cmd,
    input logic [31:0]        cfg_addr,
    input logic [3:0]         cfg_be,
    input logic [NUM_DEV-1:0] cfg_idsel
);
    // R4
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_cmd == 4'b1010 || cfg_cmd == 4'b1011));

    // R5
    idsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> $onehot0(cfg_idsel));

    // R6
    fwd_no_idsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_addr[1:0] == 2'b01) |-> (cfg_idsel == '0));

    // R7
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && $past(cfg_req)) |->
            ($stable(cfg_addr) && $stable(cfg_cmd) && $stable(cfg_be) && $stable(cfg_idsel)));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !host_ready);

    // R8
    done_follows_cplt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_done) |=> (host_done && !cfg_req));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
endmodule

bind cfg_access_bridge cfg_access_bridge_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .host_done  (host_done),
    .cfg_req    (cfg_req),
    .cfg_done   (cfg_done),
    .cfg_cmd    (cfg_cmd),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_idsel  (cfg_idsel)
);

// File: tb/cfg_access_bridge_bench.sv
// Bench: sweeps pointer fields over a small configuration and checks the
// request form, select, data return, blocking and timeout at the ports.
module cfg_access_bridge_bench;
    localparam int NDEV = 8;
    localparam int TMO  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_valid = 1'b0;
    logic            host_write = 1'b0;
    logic [31:0]     host_addr = '0;
    logic [3:0]      host_be = '0;
    logic [31:0]     host_wdata = '0;
    logic            host_ready;
    logic            host_done;
    logic [31:0]     host_rdata;
    logic            cfg_req;
    logic [3:0]      cfg_cmd;
    logic [31:0]     cfg_addr;
    logic [3:0]      cfg_be;
    logic [31:0]     cfg_wdata;
    logic [NDEV-1:0] cfg_idsel;
    logic            cfg_done = 1'b0;
    logic [31:0]     cfg_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    // Observations from the last access
    logic [31:0]     o_rdata;
    int              o_req_cycles;
    logic [3:0]      o_cmd;
    logic [31:0]     o_addr;
    logic [3:0]      o_be;
    logic [31:0]     o_wdata;
    logic [NDEV-1:0] o_idsel;
    logic            o_busy_ok;
    logic            o_stable_ok;
    int              o_wait;

    always #5 clk = ~clk;

    cfg_access_bridge #(.NUM_DEV(NDEV), .TIMEOUT_CYCLES(TMO)) u_cfg_access_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_be(host_be), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_done(host_done), .host_rdata(host_rdata),
        .cfg_req(cfg_req), .cfg_cmd(cfg_cmd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_idsel(cfg_idsel),
        .cfg_done(cfg_done), .cfg_rdata(cfg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One host access; the target answers after 'delay' request cycles, 0 = never
    task automatic access(input logic wr, input logic [31:0] addr, input logic [3:0] be,
                          input logic [31:0] wd, input int delay);
        bit finished = 0;
        int guard = 0;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = addr; host_be = be; host_wdata = wd;
        @(negedge clk);
        host_valid = 1'b0;
        o_req_cycles = 0; o_busy_ok = 1'b1; o_stable_ok = 1'b1; o_wait = 0;
        o_idsel = '0;
        while (!finished) begin
            cfg_done = 1'b0;
            o_wait++;
            if (host_done) begin
                o_rdata = host_rdata;
                finished = 1;
            end else begin
                if (host_ready) o_busy_ok = 1'b0;
                if (cfg_req) begin
                    if (o_req_cycles == 0) begin
                        o_cmd = cfg_cmd; o_addr = cfg_addr; o_be = cfg_be;
                        o_wdata = cfg_wdata; o_idsel = cfg_idsel;
                    end else if (cfg_addr !== o_addr || cfg_cmd !== o_cmd ||
                                 cfg_idsel !== o_idsel || cfg_be !== o_be) begin
                        o_stable_ok = 1'b0;
                    end
                    o_req_cycles++;
                    if (delay != 0 && o_req_cycles == delay) begin
                        cfg_done = 1'b1;
                        cfg_rdata = cfg_addr ^ 32'hA5A5_0000;
                    end
                end
                guard++;
                if (guard > TMO + 8) begin
                    check("R11 done missing", 32'd0, 32'd1);
                    finished = 1;
                end
                if (!finished) @(negedge clk);
            end
        end
        cfg_done = 1'b0;
    endtask

    function automatic logic [31:0] exp_addr(input int bus, input int dev,
                                             input int fn, input int dw);
        if (bus == 0) return {21'd0, 3'(fn), 6'(dw), 2'b00};
        return {8'd0, 8'(bus), 5'(dev), 3'(fn), 6'(dw), 2'b01};
    endfunction

    function automatic logic [31:0] exp_sel(input int bus, input int dev);
        if (bus == 0 && dev < NDEV) return 32'd1 << dev;
        return 32'd0;
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int buses[3] = '{0, 1, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 host_ready", 32'(host_ready), 32'd1);
        check("R1 cfg_req", 32'(cfg_req), 32'd0);
        check("R1 host_done", 32'(host_done), 32'd0);
        access(1'b0, 32'h0CF8, 4'hF, 0, 1);
        check("R1 pointer reset", o_rdata, 32'd0);

        // R2 full write loads, reserved bits read zero, partial write ignored
        access(1'b1, 32'h0CF8, 4'hF, 32'hFFFF_FFFF, 1);
        access(1'b0, 32'h0CF8, 4'hF, 0, 1);
        check("R2 readback", o_rdata, 32'h80FF_FFFF);
        access(1'b1, 32'h0CF8, 4'h3, 32'h0, 1);
        check("R2 partial no req", 32'(o_req_cycles), 32'd0);
        access(1'b0, 32'h0CF8, 4'h1, 0, 1);
        check("R2 partial ignored", o_rdata, 32'h80FF_FFFF);

        // R3 enable clear blocks the data port
        access(1'b1, 32'h0CF8, 4'hF, 32'h0000_0804, 1);
        access(1'b0, 32'h0CFC, 4'hF, 0, 1);
        check("R3 read ones", o_rdata, 32'hFFFF_FFFF);
        check("R3 read no req", 32'(o_req_cycles), 32'd0);
        check("R3 done next cycle", 32'(o_wait), 32'd1);
        access(1'b1, 32'h0CFC, 4'hF, 32'h1234_5678, 1);
        check("R3 write no req", 32'(o_req_cycles), 32'd0);

        // R10 stray addresses
        access(1'b0, 32'h0CF9, 4'hF, 0, 1);
        check("R10 stray read ones", o_rdata, 32'hFFFF_FFFF);
        check("R10 stray no req", 32'(o_req_cycles), 32'd0);
        check("R10 done next cycle", 32'(o_wait), 32'd1);
        access(1'b1, 32'h1CF8, 4'hF, 32'h8000_0000, 1);
        check("R10 stray write no req", 32'(o_req_cycles), 32'd0);
        access(1'b0, 32'h0CF8, 4'hF, 0, 1);
        check("R10 pointer untouched", o_rdata, 32'h0000_0804);

        // R4 R5 R6 R7 R8 sweep over bus and device fields
        foreach (buses[b]) begin
            for (int dev = 0; dev < NDEV + 2; dev++) begin
                int bus = buses[b];
                int fn = dev % 8;
                int dw = (dev * 7 + bus) % 64;
                int dly = 1 + (dev % 3);
                logic [31:0] ptr;
                logic [31:0] ea;
                ptr = {1'b1, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(dw), 2'b10};
                ea = exp_addr(bus, dev, fn, dw);
                access(1'b1, 32'h0CF8, 4'hF, ptr, 1);
                access(1'b0, 32'h0CFC, 4'hF, 0, dly);
                check("R4 read cmd", 32'(o_cmd), 32'hA);
                check((bus == 0) ? "R5 addr" : "R6 addr", o_addr, ea);
                check((bus == 0) ? "R5 idsel" : "R6 idsel", 32'(o_idsel), exp_sel(bus, dev));
                check("R8 read data", o_rdata, ea ^ 32'hA5A5_0000);
                check("R7 held until done", 32'(o_req_cycles), 32'(dly));
                check("R7 busy", 32'(o_busy_ok), 32'd1);
                check("R7 stable", 32'(o_stable_ok), 32'd1);
                access(1'b1, 32'h0CFC, 4'(dev), 32'hC0DE_0000 + 32'(dev), 1);
                check("R4 write cmd", 32'(o_cmd), 32'hB);
                check("R4 write be", 32'(o_be), 32'(dev % 16));
                check("R4 write data", o_wdata, 32'hC0DE_0000 + 32'(dev));
                check("R8 write done ones", o_rdata, 32'hFFFF_FFFF);
            end
        end

        // R9 timeout on read and write
        access(1'b1, 32'h0CF8, 4'hF, 32'h8003_1A0C, 1);
        access(1'b0, 32'h0CFC, 4'hF, 0, 0);
        check("R9 read timeout cycles", 32'(o_req_cycles), 32'(TMO));
        check("R9 read timeout ones", o_rdata, 32'hFFFF_FFFF);
        access(1'b1, 32'h0CFC, 4'hF, 32'h5555_AAAA, 0);
        check("R9 write timeout cycles", 32'(o_req_cycles), 32'(TMO));
        // R9 bridge recovers after timeout
        access(1'b0, 32'h0CFC, 4'hF, 0, 2);
        check("R9 recover data", o_rdata, exp_addr(3, 3, 2, 3) ^ 32'hA5A5_0000);
        @(negedge clk);
        check("R11 single pulse", 32'(host_done), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule